// File: doc/BRIEF.md
# Transceiver Management Registers with Masked Channel Reset

This block is the word-addressed register window that a management processor uses to watch and control a multi-channel serial transceiver. It sits on a memory-mapped slave port with a wait-request handshake. It reports which transmit PLLs are locked. It holds a per-channel enable mask. It offers one command word that starts a transmit-side or receive-side digital reset on the enabled channels.

Each command holds the chosen channels' reset lines high for a fixed, parameterized number of cycles. The same address, when read, gives a ready flag for each direction. A flag stays low until the pulse has ended and every channel it touched reports ready again. Software writes the mask, issues the command and then polls the same word until both flags return high.

Top module: `xcvr_mgmt_regs`

## Requirements
- R1: Every new read or write sees `busWait` high for exactly one cycle. The access is taken in the following cycle, when `busWait` is low, and read data is valid on `busRdata` in that same cycle.
- R2: Word 0x022 is read-only. Bit P reads `pllLock[P]` and the bits above `NUM_PLL` read zero. A write to it changes nothing.
- R3: Word 0x041 holds the channel mask. Bits 0 to `NUM_CHAN-1` read back as written, the bits above read zero, and after reset the mask is all ones over `NUM_CHAN` bits.
- R4: A write to word 0x042 with bit 0 set drives `txRstOut` equal to the mask for exactly `RST_CYCLES` cycles. The pulse starts in the cycle after the write is taken. Unmasked channels stay low, and `rxRstOut` stays low unless bit 1 is also set.
- R5: A write to word 0x042 with bit 1 set does the same on `rxRstOut`. With both bits set, both directions pulse together.
- R6: Command bits written as 0 start nothing and are not stored. Reading word 0x042 always returns status, never the value that was written.
- R7: Reading word 0x042 returns the TX ready flag in bit 0 and the RX ready flag in bit 1, with all other bits zero. A flag is 1 after reset. It drops when its command is taken and returns only after the pulse ends and every channel in that pulse has its ready input high.
- R8: Reads of any other word address return zero, and writes to them change no register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Word address |
| busWrite | input | 1 | Write request |
| busRead | input | 1 | Read request |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while `busWait` is low in a read |
| busWait | output | 1 | Access not yet taken; hold request stable |
| pllLock | input | NUM_PLL | Lock indication per transmit PLL |
| txReadyIn | input | NUM_CHAN | Per-channel TX ready feedback |
| rxReadyIn | input | NUM_CHAN | Per-channel RX ready feedback |
| txRstOut | output | NUM_CHAN | Per-channel TX digital reset |
| rxRstOut | output | NUM_CHAN | Per-channel RX digital reset |

## Verification
The reset command is tried under all sixteen values of a four-channel mask, once for each of the TX, RX and combined command codes. This shows whether the pulse follows the mask, whether it lands on the right direction, and whether it lasts the right number of cycles. Mask writes carry ones in the unused upper bits, which exposes any leak above the channel count. The ready flag is tested with one channel holding back its ready input and then releasing it, which separates "pulse ended" from "channels ready". Zero-valued commands, writes to the lock word and accesses to unmapped words show that nothing changes where nothing should.

// File: rtl/xcvr_mgmt_pkg.sv
package xcvr_mgmt_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LOCK = 2'd1,
    SEL_MASK = 2'd2,
    SEL_STAT = 2'd3
  } regSel_e;

  // Strobes from the bus control to the register datapath
  typedef struct packed {
    logic    capture;  // latch read data this cycle
    regSel_e sel;      // decoded target word
    logic    wrMask;   // commit mask write
    logic    wrCmd;    // commit command write
  } mgmtStrobe_t;

endpackage

// File: rtl/xcvr_mgmt_ctrl.sv
module xcvr_mgmt_ctrl
  import xcvr_mgmt_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int LOCK_ADDR = 'h022,
  parameter int MASK_ADDR = 'h041,
  parameter int CMD_ADDR  = 'h042
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  output logic              busWait,
  output mgmtStrobe_t       strb
);

  logic    accepted;
  logic    access;
  regSel_e sel;

  assign access  = busRead | busWrite;
  assign busWait = access & ~accepted;

  // One wait cycle, then one accept cycle, then back to idle
  always_ff @(posedge clk) begin
    if (!rstN)        accepted <= 1'b0;
    else if (busWait) accepted <= 1'b1;
    else              accepted <= 1'b0;
  end

  always_comb begin
    if (busAddr == ADDR_W'(LOCK_ADDR))      sel = SEL_LOCK;
    else if (busAddr == ADDR_W'(MASK_ADDR)) sel = SEL_MASK;
    else if (busAddr == ADDR_W'(CMD_ADDR))  sel = SEL_STAT;
    else                                    sel = SEL_NONE;
  end

  always_comb begin
    strb.capture = busWait & busRead;
    strb.sel     = sel;
    strb.wrMask  = accepted & busWrite & (sel == SEL_MASK);
    strb.wrCmd   = accepted & busWrite & (sel == SEL_STAT);
  end

  // R1: a wait cycle is always followed by an accept cycle
  p_wait_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    busWait |=> !busWait);

endmodule

// File: rtl/xcvr_mgmt_dp.sv
module xcvr_mgmt_dp
  import xcvr_mgmt_pkg::*;
#(
  parameter int NUM_CHAN   = 4,
  parameter int NUM_PLL    = 2,
  parameter int RST_CYCLES = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  mgmtStrobe_t         strb,
  input  logic [31:0]         busWdata,
  input  logic [NUM_PLL-1:0]  pllLock,
  input  logic [NUM_CHAN-1:0] txReadyIn,
  input  logic [NUM_CHAN-1:0] rxReadyIn,
  output logic [31:0]         busRdata,
  output logic [NUM_CHAN-1:0] txRstOut,
  output logic [NUM_CHAN-1:0] rxRstOut
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam int NDIR  = 2;  // index 0 = TX, 1 = RX

  logic [NUM_CHAN-1:0]            maskReg;
  logic [NDIR-1:0][NUM_CHAN-1:0]  readyIn;
  logic [NDIR-1:0][NUM_CHAN-1:0]  heldSet;
  logic [NDIR-1:0][NUM_CHAN-1:0]  rstOut;
  logic [NDIR-1:0][CNT_W-1:0]     count;
  logic [NDIR-1:0]                active;
  logic [NDIR-1:0]                pending;
  logic [NDIR-1:0]                launch;
  logic [31:0]                    rdNext;
  logic                           unusedBits;

  assign unusedBits = ^busWdata;
  assign readyIn[0] = txReadyIn;
  assign readyIn[1] = rxReadyIn;

  always_ff @(posedge clk) begin
    if (!rstN)            maskReg <= '1;
    else if (strb.wrMask) maskReg <= busWdata[NUM_CHAN-1:0];
  end

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    assign launch[d] = strb.wrCmd & busWdata[d] & (|maskReg);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        active[d]  <= 1'b0;
        pending[d] <= 1'b0;
        count[d]   <= '0;
        heldSet[d] <= '0;
      end else if (launch[d]) begin
        active[d]  <= 1'b1;
        pending[d] <= 1'b1;
        count[d]   <= CNT_W'(RST_CYCLES - 1);
        heldSet[d] <= active[d] ? (heldSet[d] | maskReg) : maskReg;
      end else begin
        if (active[d]) begin
          if (count[d] == '0) active[d] <= 1'b0;
          else                count[d]  <= count[d] - 1'b1;
        end
        if (pending[d] && !active[d] && (&(readyIn[d] | ~heldSet[d])))
          pending[d] <= 1'b0;
      end
    end

    assign rstOut[d] = active[d] ? heldSet[d] : '0;
  end

  assign txRstOut = rstOut[0];
  assign rxRstOut = rstOut[1];

  always_comb begin
    rdNext = '0;
    case (strb.sel)
      SEL_LOCK: rdNext[NUM_PLL-1:0]  = pllLock;
      SEL_MASK: rdNext[NUM_CHAN-1:0] = maskReg;
      SEL_STAT: rdNext[1:0]          = ~pending;
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             busRdata <= '0;
    else if (strb.capture) busRdata <= rdNext;
  end

  // R4: newly raised TX reset lines were all enabled in the mask
  p_tx_masked_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|(txRstOut & ~$past(txRstOut))) |-> ((txRstOut & ~$past(txRstOut) & ~$past(maskReg)) == '0));
  // R4: a TX pulse only begins after a TX command strobe
  p_tx_from_cmd_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|(txRstOut & ~$past(txRstOut))) |-> $past(strb.wrCmd && busWdata[0]));
  // R5: an RX pulse only begins after an RX command strobe
  p_rx_from_cmd_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|(rxRstOut & ~$past(rxRstOut))) |-> $past(strb.wrCmd && busWdata[1]));
  // R7: ready flags are low while the matching reset is held
  p_ready_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((|txRstOut) |-> pending[0]) and ((|rxRstOut) |-> pending[1]));
  // R8: unmapped reads return zero
  p_undef_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && strb.sel == SEL_NONE) |=> (busRdata == '0));

endmodule

// File: rtl/xcvr_mgmt_regs.sv
module xcvr_mgmt_regs
  import xcvr_mgmt_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int NUM_CHAN   = 4,
  parameter int NUM_PLL    = 2,
  parameter int RST_CYCLES = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWrite,
  input  logic                busRead,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                busWait,
  input  logic [NUM_PLL-1:0]  pllLock,
  input  logic [NUM_CHAN-1:0] txReadyIn,
  input  logic [NUM_CHAN-1:0] rxReadyIn,
  output logic [NUM_CHAN-1:0] txRstOut,
  output logic [NUM_CHAN-1:0] rxRstOut
);

  mgmtStrobe_t strb;

  xcvr_mgmt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busRead(busRead), .busWait(busWait), .strb(strb)
  );

  xcvr_mgmt_dp #(.NUM_CHAN(NUM_CHAN), .NUM_PLL(NUM_PLL), .RST_CYCLES(RST_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .pllLock(pllLock),
    .txReadyIn(txReadyIn), .rxReadyIn(rxReadyIn), .busRdata(busRdata),
    .txRstOut(txRstOut), .rxRstOut(rxRstOut)
  );

endmodule

// File: tb/xcvr_mgmt_regs_test.sv
`timescale 1ns/1ps
module xcvr_mgmt_regs_test;

  localparam int NCH = 4;
  localparam int NPL = 2;
  localparam int RCY = 5;
  localparam logic [9:0] A_LOCK = 10'h022;
  localparam logic [9:0] A_MASK = 10'h041;
  localparam logic [9:0] A_CMD  = 10'h042;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [9:0] busAddr = '0;
  logic busWrite = 1'b0, busRead = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic busWait;
  logic [NPL-1:0] pllLock = '0;
  logic [NCH-1:0] txReadyIn = '1, rxReadyIn = '1;
  logic [NCH-1:0] txRstOut, rxRstOut;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  xcvr_mgmt_regs #(.ADDR_W(10), .NUM_CHAN(NCH), .NUM_PLL(NPL), .RST_CYCLES(RCY)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite), .busRead(busRead),
    .busWdata(busWdata), .busRdata(busRdata), .busWait(busWait), .pllLock(pllLock),
    .txReadyIn(txReadyIn), .rxReadyIn(rxReadyIn), .txRstOut(txRstOut), .rxRstOut(rxRstOut)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doWrite(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = d; busWrite = 1'b1;
    #1 chk(busWait === 1'b1, "R1 write wait", 32'(busWait), 1);
    @(negedge clk);
    chk(busWait === 1'b0, "R1 write accept", 32'(busWait), 0);
    @(negedge clk); busWrite = 1'b0;
  endtask

  task automatic doRead(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; busRead = 1'b1;
    #1 chk(busWait === 1'b1, "R1 read wait", 32'(busWait), 1);
    @(negedge clk);
    chk(busWait === 1'b0, "R1 read accept", 32'(busWait), 0);
    d = busRdata;
    @(negedge clk); busRead = 1'b0;
  endtask

  // Check both reset buses for RCY cycles, then check that they are low
  task automatic chkPulse(input logic [NCH-1:0] expTx, input logic [NCH-1:0] expRx, input string tag);
    for (int k = 0; k < RCY; k++) begin
      #1;
      chk(txRstOut === expTx, {tag, " tx during"}, 32'(txRstOut), 32'(expTx));
      chk(rxRstOut === expRx, {tag, " rx during"}, 32'(rxRstOut), 32'(expRx));
      @(negedge clk);
    end
    #1;
    chk(txRstOut === '0, {tag, " tx released"}, 32'(txRstOut), 0);
    chk(rxRstOut === '0, {tag, " rx released"}, 32'(rxRstOut), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(txRstOut === '0 && rxRstOut === '0, "R4 reset lines low", 32'({txRstOut, rxRstOut}), 0);
    chk(busWait === 1'b0, "R1 idle no wait", 32'(busWait), 0);
    doRead(A_MASK, rd); chk(rd === 32'hF, "R3 mask reset value", rd, 32'hF);
    doRead(A_CMD, rd);  chk(rd === 32'h3, "R7 ready after reset", rd, 32'h3);

    // R2: sweep every lock pattern; a write to the lock word is ignored
    for (int p = 0; p < (1 << NPL); p++) begin
      pllLock = NPL'(p);
      doRead(A_LOCK, rd); chk(rd === 32'(p), "R2 lock word", rd, 32'(p));
    end
    doWrite(A_LOCK, 32'h0);
    doRead(A_LOCK, rd); chk(rd === 32'(pllLock), "R2 lock write ignored", rd, 32'(pllLock));

    // R3, R4, R5: every mask value with each command code
    for (int v = 0; v < (1 << NCH); v++) begin
      doWrite(A_MASK, 32'hFFFF_FFF0 | 32'(v));
      doRead(A_MASK, rd); chk(rd === 32'(v), "R3 mask readback", rd, 32'(v));
      doWrite(A_CMD, 32'h1); chkPulse(NCH'(v), '0, "R4 tx cmd");
      doWrite(A_CMD, 32'h2); chkPulse('0, NCH'(v), "R5 rx cmd");
      doWrite(A_CMD, 32'h3); chkPulse(NCH'(v), NCH'(v), "R5 both cmd");
    end

    // R6: zero command bits do nothing and are not stored
    doWrite(A_MASK, 32'hF);
    doWrite(A_CMD, 32'h0); chkPulse('0, '0, "R6 zero cmd");
    doRead(A_CMD, rd); chk(rd === 32'h3, "R6 status not written value", rd, 32'h3);

    // R7: ready stays low until the pulse ends and channels report ready
    txReadyIn = 4'b1110;
    doWrite(A_CMD, 32'h1);
    doRead(A_CMD, rd); chk(rd === 32'h2, "R7 tx not ready during pulse", rd, 32'h2);
    repeat (RCY + 2) @(negedge clk);
    chk(txRstOut === '0, "R7 pulse ended", 32'(txRstOut), 0);
    doRead(A_CMD, rd); chk(rd === 32'h2, "R7 tx waits for channel 0", rd, 32'h2);
    txReadyIn = 4'b1111;
    repeat (2) @(negedge clk);
    doRead(A_CMD, rd); chk(rd === 32'h3, "R7 tx ready again", rd, 32'h3);
    rxReadyIn = 4'b0111;
    doWrite(A_CMD, 32'h2);
    repeat (RCY + 2) @(negedge clk);
    doRead(A_CMD, rd); chk(rd === 32'h1, "R7 rx waits for channel 3", rd, 32'h1);
    rxReadyIn = 4'b1111;
    repeat (2) @(negedge clk);
    doRead(A_CMD, rd); chk(rd === 32'h3, "R7 rx ready again", rd, 32'h3);

    // R8: unmapped addresses
    doRead(10'h000, rd); chk(rd === 32'h0, "R8 read 0x000", rd, 0);
    doRead(10'h043, rd); chk(rd === 32'h0, "R8 read 0x043", rd, 0);
    doRead(10'h040, rd); chk(rd === 32'h0, "R8 read 0x040", rd, 0);
    doWrite(10'h040, 32'h0); chkPulse('0, '0, "R8 write 0x040");
    doWrite(10'h043, 32'h3); chkPulse('0, '0, "R8 write 0x043");
    doRead(A_MASK, rd); chk(rd === 32'hF, "R8 mask unchanged", rd, 32'hF);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule